// File: doc/BRIEF.md
# Serial Block Receive DMA Engine

This engine moves a block of bytes from a high-speed serial receiver into 16-bit-wide memory without help from the processor. Software programs two registers over a simple register port. The first is a base byte address. The second is a length counter, loaded with the number of words minus one. Writing the length counter starts the transfer.

Incoming bytes are paired into little-endian 16-bit words. Each word is written to memory at the base address plus two times its word index. The counter counts down once per stored word, so reading it during a transfer gives the remaining length. After the final word, a one-cycle done pulse is raised, the engine returns to idle, and the counter holds all-ones until software loads it again.

Top module: `blk_rx_dma`

## Requirements
- R1: After reset, the base register reads 0, the length register reads 0, and neither `mem_we` nor `done` is asserted.
- R2: The base register is a 16-bit read/write register selected by `reg_sel`=0. A read returns data on `reg_rdata` one cycle after `reg_rd`, and `reg_rdata` holds that value until the next read.
- R3: The length register (`reg_sel`=1) keeps only `reg_wdata[9:0]`. Bits 15:10 are ignored on write and read back as 0.
- R4: Writing the length register starts a transfer. Bytes with `rx_valid` high while no transfer is active are dropped and cause no memory write.
- R5: Two successive accepted bytes form one word. The first byte goes in bits 7:0 and the second in bits 15:8. `mem_we` rises in the cycle after the second byte is sampled.
- R6: Word k of a transfer is written at (base + 2k) mod 2^16. The base is captured when the length is written, so a base write during a transfer affects only later transfers. The base register still reads back the programmed value.
- R7: The length register decrements once per word written. A read during a transfer returns the number of words still to come, minus one.
- R8: The word written while the counter is 0 is the last one. `done` is high for exactly the cycle of that write. The length register then reads 0x3FF until it is written again.
- R9: A length write during an active transfer aborts it. Any half-built word is discarded, and a new transfer restarts at word 0 of the current base with the new length.
- R10: A length value of 0x3FF transfers 1024 words (2048 bytes). A length of 0 transfers one word.
- R11: A byte presented in the same cycle as a length write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 = base, 1 = length |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle latency |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
If the byte-pairing state is wrong, the half-word phase shifts. Every following word then comes out with swapped or misaligned bytes, and this shows on `mem_wdata` at the very next write. A wrong pointer shows on `mem_addr` at the next write. A wrong counter shows up either at the next length read or as a `done` pulse arriving on the wrong word, which may be up to a full transfer later. The reference model is compared every cycle against the write port, the done pulse and the read data, so any drift is reported in the cycle where it first becomes visible.

// File: rtl/blk_rx_dma_pkg.sv
package blk_rx_dma_pkg;

  // register select encoding on the register port
  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_LEN  = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/rxd_regs.sv
module rxd_regs
  import blk_rx_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [BUS_W-1:0]  reg_wdata,
  input  logic [LEN_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              start_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [BUS_W-1:0]  rdata_o
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [BUS_W-1:0]  rdata_q, rdata_d;
  logic              base_en;

  assign base_en = reg_wr && (reg_sel == SEL_BASE);
  assign start_o = reg_wr && (reg_sel == SEL_LEN);
  assign len_o   = reg_wdata[LEN_W-1:0];

  always_comb begin
    base_d = base_q;
    if (base_en) base_d = reg_wdata[ADDR_W-1:0];
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd) begin
      if (reg_sel == SEL_LEN) rdata_d = BUS_W'(cnt_i);
      else                    rdata_d = BUS_W'(base_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (base_en) base_q  <= base_d;
      if (reg_rd)  rdata_q <= rdata_d;
    end
  end

  assign base_o  = base_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);

  logic              half_q, half_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              take;

  assign take = en && rx_valid;

  always_comb begin
    half_d = half_q;
    lo_d   = lo_q;
    if (clr) begin
      half_d = 1'b0;
    end else if (take) begin
      if (!half_q) begin
        lo_d   = rx_byte;
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      if (clr || take) half_q <= half_d;
      if (take)        lo_q   <= lo_d;
    end
  end

  assign word_vld_o = take && half_q && !clr;
  assign word_o     = {rx_byte, lo_q};

endmodule

// File: rtl/rxd_seq.sv
module rxd_seq #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10,
  parameter int WORD_W = 16,
  localparam logic [ADDR_W-1:0] PTR_STEP = ADDR_W'(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [ADDR_W-1:0] base,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output logic              active_o,
  output logic [LEN_W-1:0]  cnt_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              done_o
);

  logic              act_q, act_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              done_q, done_d;
  logic              last;
  logic              state_en;

  assign last     = (cnt_q == '0);
  assign state_en = start || word_vld;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    we_d   = 1'b0;
    done_d = 1'b0;
    addr_d = addr_q;
    data_d = data_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = start_len;
      ptr_d = base;
    end else if (word_vld) begin
      we_d   = 1'b1;
      addr_d = ptr_q;
      data_d = word;
      ptr_d  = ptr_q + PTR_STEP;
      if (last) begin
        cnt_d  = '1;
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      we_q   <= we_d;
      done_q <= done_d;
      if (state_en) begin
        act_q <= act_d;
        cnt_q <= cnt_d;
        ptr_q <= ptr_d;
      end
      if (word_vld) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  assign active_o    = act_q;
  assign cnt_o       = cnt_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign done_o      = done_q;

endmodule

// File: rtl/blk_rx_dma.sv
module blk_rx_dma #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10,
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done
);

  logic [ADDR_W-1:0] base_addr;
  logic              xfer_start;
  logic [LEN_W-1:0]  start_len;
  logic [LEN_W-1:0]  len_cnt;
  logic              xfer_active;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              pack_en;

  assign pack_en = xfer_active && !xfer_start;

  rxd_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_W(BUS_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .cnt_i     (len_cnt),
    .base_o    (base_addr),
    .start_o   (xfer_start),
    .len_o     (start_len),
    .rdata_o   (reg_rdata)
  );

  rxd_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (pack_en),
    .clr        (xfer_start),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  rxd_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (xfer_start),
    .start_len   (start_len),
    .base        (base_addr),
    .word_vld    (word_vld),
    .word        (word),
    .active_o    (xfer_active),
    .cnt_o       (len_cnt),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .done_o      (done)
  );

endmodule

// File: rtl/blk_rx_dma_chk.sv
module blk_rx_dma_chk #(
  parameter int LEN_W = 10,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_we,
  input logic             done,
  input logic             active,
  input logic [LEN_W-1:0] cnt,
  input logic             reg_rd,
  input logic             reg_sel,
  input logic [BUS_W-1:0] reg_rdata
);

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mem_we);

  // R8
  done_cnt_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == '1) && !active);

  // R4
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(active));

  // R3
  len_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd && reg_sel) |-> (reg_rdata[BUS_W-1:LEN_W] == '0));

endmodule

bind blk_rx_dma blk_rx_dma_chk #(.LEN_W(LEN_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_we    (mem_we),
  .done      (done),
  .active    (xfer_active),
  .cnt       (len_cnt),
  .reg_rd    (reg_rd),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata)
);

// File: tb/blk_rx_dma_bench.sv
module blk_rx_dma_bench;

  logic        clk;
  logic        rst_n;
  logic        reg_wr, reg_rd, reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        done;

  int errors = 0;
  int checks = 0;
  int words_seen = 0;
  bit finished = 0;

  // behavioural reference state
  int m_base, m_cnt, m_ptr, m_lo;
  bit m_act, m_half;
  bit e_we, e_done;
  int e_addr, e_data, e_rdata;

  blk_rx_dma u_blk_rx_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference model update for one rising edge
  task automatic model_edge();
    e_we = 0;
    e_done = 0;
    if (reg_rd) e_rdata = reg_sel ? m_cnt : m_base;
    if (reg_wr && !reg_sel) m_base = reg_wdata;
    if (reg_wr && reg_sel) begin
      m_cnt = reg_wdata & 16'h03FF;
      m_act = 1;
      m_half = 0;
      m_ptr = m_base;
    end else if (m_act && rx_valid) begin
      if (!m_half) begin
        m_lo = rx_byte;
        m_half = 1;
      end else begin
        e_we = 1;
        e_addr = m_ptr;
        e_data = (rx_byte << 8) | m_lo;
        m_ptr = (m_ptr + 2) & 16'hFFFF;
        m_half = 0;
        if (m_cnt == 0) begin
          m_cnt = 16'h03FF;
          m_act = 0;
          e_done = 1;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
    end
  endtask

  task automatic step(bit wr, bit rd, bit sel, int wd, bit v, int b);
    reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = 16'(wd);
    rx_valid = v; rx_byte = 8'(b);
    @(posedge clk);
    model_edge();
    #1;
    check("R4 mem_we", int'(mem_we), int'(e_we));
    if (e_we) begin
      check("R6 mem_addr", int'(mem_addr), e_addr);
      check("R5 mem_wdata", int'(mem_wdata), e_data);
    end
    check("R8 done", int'(done), int'(e_done));
    check("R7 reg_rdata", int'(reg_rdata), e_rdata);
    if (mem_we) words_seen++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic wreg(bit sel, int d);
    step(1, 0, sel, d, 0, 0);
  endtask

  task automatic rreg(bit sel);
    step(0, 1, sel, 0, 0, 0);
  endtask

  task automatic send(int b);
    step(0, 0, 0, 0, 1, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    m_base = 0; m_cnt = 0; m_ptr = 0; m_lo = 0; m_act = 0; m_half = 0;
    e_we = 0; e_done = 0; e_addr = 0; e_data = 0; e_rdata = 0;
    rst_n = 0;
    reg_wr = 0; reg_rd = 0; reg_sel = 0; reg_wdata = 0;
    rx_valid = 0; rx_byte = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 mem_we", int'(mem_we), 0);
    check("R1 done", int'(done), 0);
    rreg(0); check("R1 base", int'(reg_rdata), 0);
    rreg(1); check("R1 len", int'(reg_rdata), 0);

    // R4 bytes while idle are dropped
    for (int i = 0; i < 6; i++) send(8'hA0 + i);
    check("R4 no words while idle", words_seen, 0);

    // R2 base register
    wreg(0, 16'h1234);
    rreg(0); check("R2 base readback", int'(reg_rdata), 16'h1234);
    idle(1); check("R2 rdata held", int'(reg_rdata), 16'h1234);

    // R3 reserved bits dropped, also starts 3-word transfer
    wreg(1, 16'hFC02);
    rreg(1); check("R3 len readback", int'(reg_rdata), 16'h0002);
    send(8'h11); send(8'h22);
    check("R5 first word", int'(mem_wdata), 16'h2211);
    check("R6 first addr", int'(mem_addr), 16'h1234);
    rreg(1); check("R7 remaining", int'(reg_rdata), 16'h0001);
    send(8'h33); idle(2); send(8'h44);
    send(8'h55); send(8'h66);
    check("R8 done on last", int'(done), 1);
    check("R6 third addr", int'(mem_addr), 16'h1238);
    idle(1); check("R8 done one cycle", int'(done), 0);
    rreg(1); check("R8 len all ones", int'(reg_rdata), 16'h03FF);
    for (int i = 0; i < 4; i++) send(i);
    rreg(1); check("R8 len held", int'(reg_rdata), 16'h03FF);

    // R6 base write during transfer does not move current transfer
    wreg(0, 16'hFFFC);
    wreg(1, 16'h0002);
    send(8'h01); send(8'h02);
    wreg(0, 16'h4000);
    send(8'h03); send(8'h04);
    check("R6 wrap addr", int'(mem_addr), 16'hFFFE);
    send(8'h05); send(8'h06);
    check("R6 wrapped addr", int'(mem_addr), 16'h0000);
    rreg(0); check("R6 base reads programmed", int'(reg_rdata), 16'h4000);

    // R9 abort mid-word, restart with new length
    wreg(1, 16'h0004);
    send(8'hAA); send(8'hBB); send(8'hCC);
    wreg(1, 16'h0001);
    send(8'hDD); send(8'hEE);
    check("R9 restart addr", int'(mem_addr), 16'h4000);
    check("R9 discarded half", int'(mem_wdata), 16'hEEDD);
    send(8'h01); send(8'h02);
    check("R9 done new length", int'(done), 1);

    // R11 byte with length write dropped
    step(1, 0, 1, 16'h0000, 1, 8'h77);
    send(8'h10); send(8'h20);
    check("R11 word excludes byte", int'(mem_wdata), 16'h2010);
    check("R10 length zero single word", int'(done), 1);

    // R10 maximum length
    wreg(0, 16'h0100);
    words_seen = 0;
    wreg(1, 16'h03FF);
    for (int i = 0; i < 2048; i++) begin
      send(i & 8'hFF);
      if ((i % 97) == 0) idle(1);
    end
    idle(2);
    check("R10 1024 words", words_seen, 1024);
    check("R10 last addr", int'(mem_addr), 16'h0100 + 2 * 1023);
    rreg(1); check("R10 len after max", int'(reg_rdata), 16'h03FF);

    summary();
  end

endmodule